// File: doc/BRIEF.md
# Configurable Four-Macrocell Logic Block

This block is a small programmable logic cell. Eighteen logic inputs go into a shared array of product terms, and four macrocells are built from that array. Each product term is set by two masks. One mask selects true literals and the other selects complemented literals. Each macrocell takes one of two paths:

- a fast path that ORs four fixed terms;
- a general path that ORs any subset of the twenty array terms and then passes the result through an XOR stage.

Each output can then be taken straight from its path or from a register.

Three extra terms have fixed jobs: one gives an asynchronous register clear, one gives an output-enable, and one gives a locally generated clock. The register clock for the whole block is one of three global clocks or that product-term clock.

Configuration lives in a parallel register file. It is written one row at a time on the rising edge of global clock 0 while the load input is high. While loading, the outputs read as zero, so a partly written setup is never visible. The same block can hold a counter, a decoder or an XOR function, depending on what is loaded.

Top module: `cfg_logic_block`

## Requirements
- R1: A product term is 1 exactly when every input selected by its true mask is 1 and every input selected by its complement mask is 0, and at least one mask bit is set. Configuration rows 0 to 19 are the array terms. Row 20 is the clear term, row 21 the enable term and row 22 the clock term. In each row, bits [17:0] are the true mask and bits [35:18] the complement mask, with bit n tied to input n.
- R2: A term whose masks are both all zero reads 0, so it has no effect on any output it feeds.
- R3: Output i is controlled by row 23+1+i. In that row, bits [19:0] select array terms, [24:20] is the XOR select, [25] is the polarity bit, [26] picks the fast path and [27] makes the output registered. On the general path the output is the OR of the selected terms, XORed with the term named by the XOR select when that value is below 20, and with the polarity bit otherwise.
- R4: On the fast path, output i is the OR of array terms 4i to 4i+3. The select mask, the XOR select and the polarity bit have no effect.
- R5: A registered output changes only on a rising edge of the chosen block clock, taking the value its path had before that edge. A combinational output follows the inputs in the same cycle.
- R6: Driving rst_n low clears all four registers at once, without waiting for a clock edge.
- R7: When the clear term (row 20) is 1, all four registers clear at once and stay at 0 while it remains 1, even across clock edges.
- R8: The oe output follows the enable term (row 21).
- R9: Row 23 bits [1:0] choose the block clock: 0, 1 or 2 picks that global clock, and 3 picks the clock term (row 22). Edges on any clock that is not chosen leave the registers unchanged.
- R10: A row is written on a rising edge of clk_g[0] only while cfg_load is 1. A write presented with cfg_load at 0 has no effect. While cfg_load is 1, dout and oe read 0, and the configured values return as soon as it falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_g | input | 3 | Global clocks; bit 0 also clocks configuration writes |
| rst_n | input | 1 | Active-low asynchronous clear of the macrocell registers |
| cfg_load | input | 1 | Configuration write enable; blanks the outputs while high |
| cfg_addr | input | 5 | Configuration row number |
| cfg_data | input | 36 | Configuration row contents |
| din | input | 18 | Logic inputs to the product-term array |
| dout | output | 4 | Macrocell outputs |
| oe | output | 1 | Output-enable from the dedicated term |

## Verification
The first setup is combinational: an XOR through the general path, two decoder outputs on the fast path, and a polarity-inverted term alongside an unused one. Walking the inputs through a table of cases separates the XOR stage from the plain OR, and shows whether the fast path ignores its XOR settings. The second setup is a registered two-bit counter whose state the bench feeds back as inputs. Its count sequence exposes any capture on the wrong edge, a wrong term index in the XOR stage, or a clear or clock source that does not take effect. A write made with the load input low, and the blank outputs during a load, check the configuration gate at the ports.

// File: rtl/cfg_logic_block.sv
module cfg_logic_block #(
  parameter int NIN   = 18,
  parameter int NPT   = 20,
  parameter int NOUT  = 4,
  parameter int FAST  = 4,
  parameter int NGCLK = 3
) (
  input  logic [NGCLK-1:0]        clk_g,
  input  logic                    rst_n,
  input  logic                    cfg_load,
  input  logic [$clog2(NPT+4+NOUT)-1:0] cfg_addr,
  input  logic [2*NIN-1:0]        cfg_data,
  input  logic [NIN-1:0]          din,
  output logic [NOUT-1:0]         dout,
  output logic                    oe
);
  localparam int NT    = NPT + 3;
  localparam int RST_T = NPT;
  localparam int OE_T  = NPT + 1;
  localparam int CLK_T = NPT + 2;
  localparam int AW    = $clog2(NPT + 4 + NOUT);
  localparam int XW    = $clog2(NPT);
  localparam int CSW   = $clog2(NGCLK + 1);
  localparam int DW    = 2 * NIN;

  logic [NT-1:0][NIN-1:0]   tm, cm;
  logic [NOUT-1:0][NPT-1:0] alloc;
  logic [NOUT-1:0][XW-1:0]  xsel;
  logic [NOUT-1:0]          pol, fast_m, regm;
  logic [CSW-1:0]           csel;
  logic [NT-1:0]            pt;
  logic [NPT-1:0]           apt;
  logic [NOUT-1:0]          comb, q;
  logic                     mclk, clr;

  always_ff @(posedge clk_g[0]) begin
    if (cfg_load) begin
      for (int t = 0; t < NT; t++)
        if (cfg_addr == AW'(t)) begin
          tm[t] <= cfg_data[NIN-1:0];
          cm[t] <= cfg_data[DW-1:NIN];
        end
      if (cfg_addr == AW'(NT)) csel <= cfg_data[CSW-1:0];
      for (int o = 0; o < NOUT; o++)
        if (cfg_addr == AW'(NT + 1 + o)) begin
          alloc[o]  <= cfg_data[NPT-1:0];
          xsel[o]   <= cfg_data[NPT +: XW];
          pol[o]    <= cfg_data[NPT+XW];
          fast_m[o] <= cfg_data[NPT+XW+1];
          regm[o]   <= cfg_data[NPT+XW+2];
        end
    end
  end

  for (genvar t = 0; t < NT; t++) begin : g_term
    assign pt[t] = (|(tm[t] | cm[t])) & (&(din | ~tm[t])) & (&(~din | ~cm[t]));
  end
  assign apt = pt[NPT-1:0];

  for (genvar o = 0; o < NOUT; o++) begin : g_cell
    logic orv, xb;
    assign orv     = |(apt & alloc[o]);
    assign xb      = (xsel[o] < XW'(NPT)) ? apt[xsel[o]] : pol[o];
    assign comb[o] = fast_m[o] ? |apt[o*FAST +: FAST] : (orv ^ xb);
  end

  always_comb begin
    mclk = pt[CLK_T];
    for (int c = 0; c < NGCLK; c++)
      if (csel == CSW'(c)) mclk = clk_g[c];
  end

  assign clr = ~rst_n | pt[RST_T];

  always_ff @(posedge mclk or posedge clr) begin
    if (clr) q <= '0;
    else     q <= comb;
  end

  assign dout = cfg_load ? '0 : ((regm & q) | (~regm & comb));
  assign oe   = ~cfg_load & pt[OE_T];

  p_quiet_load_r10: assert property (@(posedge clk_g[0]) disable iff (!rst_n)
    cfg_load |-> (dout == '0 && !oe));

  p_capture_r5: assert property (@(posedge clk_g[0]) disable iff (!rst_n)
    (csel == '0 && !clr) |=> (clr || q == $past(comb)));

  p_term_clear_r7: assert property (@(posedge clk_g[0]) disable iff (!rst_n)
    pt[RST_T] |-> q == '0);

  p_global_clear_r6: assert property (@(posedge clk_g[0])
    $rose(rst_n) |-> q == '0);
endmodule

// File: tb/cfg_logic_block_tb_top.sv
module cfg_logic_block_tb_top;
  logic clk0 = 1'b0, clk1 = 1'b0, clk2 = 1'b0;
  logic rst_n = 1'b0, cfg_load = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [35:0] cfg_data = '0;
  logic [13:0] stim = '0;
  logic [3:0]  fb = '0;
  logic [3:0]  dout;
  logic        oe;
  int n_chk = 0, n_err = 0;

  always #5 clk0 = ~clk0;

  cfg_logic_block dut_i (
    .clk_g({clk2, clk1, clk0}), .rst_n(rst_n), .cfg_load(cfg_load),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .din({stim, fb}),
    .dout(dout), .oe(oe));

  // stimulus {s13,s3,s2,s1,s0} -> expected {oe,o3,o2,o1,o0}
  localparam logic [9:0] VEC [8] = '{
    10'b00000_01100, 10'b00001_01101, 10'b00010_01101, 10'b00011_01100,
    10'b10100_10000, 10'b11001_11001, 10'b01110_01011, 10'b11111_11010};

  task automatic chk(input string r, input logic [4:0] exp);
    n_chk++;
    if ({oe, dout} !== exp) begin
      n_err++;
      $display("FAIL %s got=%b exp=%b", r, {oe, dout}, exp);
    end
  endtask

  task automatic wr(input int a, input logic [35:0] d);
    @(negedge clk0);
    cfg_load = 1'b1; cfg_addr = 5'(a); cfg_data = d;
    @(posedge clk0);
  endtask

  task automatic clear_all();
    for (int a = 0; a < 28; a++) wr(a, '0);
  endtask

  task automatic finish_load();
    @(negedge clk0);
    cfg_load = 1'b0; rst_n = 1'b0;
    @(negedge clk0);
    rst_n = 1'b1; fb = '0; stim = '0;
    #1;
  endtask

  function automatic logic [35:0] ctl(logic [19:0] al, logic [4:0] xs,
                                      logic p, logic f, logic r);
    return {8'b0, r, f, p, xs, al};
  endfunction

  function automatic logic [35:0] row(logic [17:0] t, logic [17:0] c);
    return {c, t};
  endfunction

  initial begin
    #1_000_000;
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    // setup 1: combinational XOR, decoder, polarity
    clear_all();
    wr(0, row(18'h10, 0));
    wr(1, row(18'h20, 0));
    wr(4, row(18'hC0, 0));
    wr(8, row(0, 18'hC0));
    wr(12, row(18'h40, 18'h80));
    wr(21, row(18'h20000, 0));
    wr(24, ctl(20'h1, 5'd1, 1'b0, 1'b0, 1'b0));
    wr(25, ctl(20'h0, 5'd0, 1'b1, 1'b1, 1'b0));
    wr(26, ctl(20'h0, 5'd31, 1'b0, 1'b1, 1'b0));
    wr(27, ctl(20'h3000, 5'd31, 1'b1, 1'b0, 1'b0));
    finish_load();

    for (int i = 0; i < 8; i++) begin
      @(negedge clk0);
      stim = '0;
      stim[3:0] = VEC[i][8:5];
      stim[13]  = VEC[i][9];
      #1 chk("R1 R2 R3 R4 R8 table", VEC[i][4:0]);
    end

    // R10: write with load low is ignored
    @(negedge clk0);
    stim = '0; cfg_addr = 5'd0; cfg_data = '0; cfg_load = 1'b0;
    @(negedge clk0);
    stim[0] = 1'b1;
    #1 chk("R10 ignored write", 5'b01101);

    // setup 2: registered two-bit counter fed back through fb
    clear_all();
    wr(0, row(0, 18'h1));
    wr(1, row(18'h2, 0));
    wr(2, row(18'h1, 0));
    wr(20, row(18'h10000, 0));
    wr(24, ctl(20'h1, 5'd31, 1'b0, 1'b0, 1'b1));
    wr(25, ctl(20'h2, 5'd2, 1'b0, 1'b0, 1'b1));
    wr(26, ctl(20'h0, 5'd31, 1'b0, 1'b0, 1'b0));
    wr(27, ctl(20'h0, 5'd31, 1'b0, 1'b0, 1'b0));
    finish_load();
    chk("R6 reset state", 5'b0);

    for (int k = 1; k <= 5; k++) begin
      @(negedge clk0);
      chk("R5 counter", 5'(k % 4));
      fb = dout;
    end

    @(negedge clk0);
    stim[12] = 1'b1; fb = dout;
    #1 chk("R7 term clear", 5'b0);
    @(negedge clk0);
    chk("R7 clear held across edge", 5'b0);
    stim[12] = 1'b0; fb = dout;
    @(negedge clk0);
    chk("R7 count resumes", 5'd1);
    fb = dout;
    @(negedge clk0);
    chk("R5 counter after clear", 5'd2);
    rst_n = 1'b0;
    #1 chk("R6 async global clear", 5'b0);
    @(negedge clk0);
    rst_n = 1'b1; fb = '0;
    @(negedge clk0);
    chk("R5 count after reset", 5'd1);
    fb = dout;

    // R10: outputs blank while loading, return afterwards
    @(negedge clk0);
    cfg_load = 1'b1; cfg_addr = 5'd23; cfg_data = '0;
    #1 chk("R10 blank during load", 5'b0);
    @(negedge clk0);
    cfg_load = 1'b0;
    #1 chk("R10 outputs return", 5'd2);

    // R9: global clock 1
    wr(23, 36'd1);
    finish_load();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk0);
      chk("R9 clk0 ignored", 5'b0);
      fb = dout;
    end
    @(negedge clk0);
    clk1 = 1'b1; #1 clk1 = 1'b0; #1;
    chk("R9 clk1 edge", 5'd1);
    fb = dout;
    @(negedge clk0);
    chk("R9 still on clk1", 5'd1);

    // R9: product-term clock on input 15 (stim[11])
    wr(22, row(18'h8000, 0));
    wr(23, 36'd3);
    finish_load();
    @(negedge clk0);
    @(negedge clk0);
    chk("R9 term clock idle", 5'b0);
    stim[11] = 1'b1; #1 stim[11] = 1'b0; #1;
    chk("R9 term clock edge", 5'd1);
    fb = dout;
    clk1 = 1'b1; #1 clk1 = 1'b0; #1;
    chk("R9 clk1 ignored", 5'd1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule